// File: doc/BRIEF.md
# Duplicate-Tag Snoop Filter

This block sits between a group of cores and the shared second-level cache. It keeps a private copy of every core's first-level tag array, together with the MESI state of each line. When a core misses or needs write permission, the block looks up that copy for all cores at once. Coherence commands therefore reach only the cores that really hold the line. The block names the peer that must supply the data, and it sends the request to L2 only when no peer holds the line.

A dirty line held by one core is handed straight to the next reader together with ownership, so L2 sees no write-back and no re-read. Cores report their own fills, evictions and silent Exclusive-to-Modified changes on an update port, so the copy tracks their caches. Each core's L1 is direct mapped. The L1 data arrays and L2 are outside the block.

Top module: `snoop_filter_dup`

## Requirements
- R1: When several cores request in the same cycle, `req_ready` is asserted combinationally for the lowest-numbered requesting core only. That request's results appear on the outputs in the following cycle. In any cycle with no accepted request, every output is zero.
- R2: The low log2(NLINE) bits of a line address are the index and the rest are the tag. State codes are I=0, S=1, E=2, M=3. A read that matches no valid copy in any core drives `l2_valid` with `l2_addr` equal to the request address and grants E. It issues no snoop and no forward.
- R3: A read that finds only clean copies (S or E) in other cores forwards from the lowest-numbered holder. It sends `snp_down` only to holders in E and grants S. Afterwards every holder is recorded as S.
- R4: Snoop commands go only to other cores whose copy at that index is valid and has an equal tag, and never to the requester. `snp_addr` carries the request address when any snoop is sent and is zero otherwise.
- R5: A read that finds the line Modified in another core sends `snp_inv` to that core and names it as the forward source. It grants M to the reader and makes no L2 request.
- R6: A write from a core that does not hold the line invalidates every other holder. The data comes from the lowest-numbered holder if there is one, and from L2 otherwise. The grant is M.
- R7: A write from a core that already holds the line invalidates every other holder. It issues no forward and no L2 request, and grants M.
- R8: A read from a core that already holds the line grants the recorded state and drives no snoop, forward or L2 request.
- R9: An update from core c writes the tag and state at that address's index into c's copy, and state I removes the line. An update alone leaves all outputs zero.
- R10: During and after reset every copy is invalid and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | NCORE | per-core miss or upgrade request |
| req_write | input | NCORE | per-core: 1 = write permission wanted |
| req_addr | input | NCORE*ADDR_W | per-core line address |
| req_ready | output | NCORE | request accepted this cycle |
| upd_valid | input | NCORE | per-core tag update |
| upd_addr | input | NCORE*ADDR_W | line address of the update |
| upd_state | input | NCORE*2 | new state reported by the core |
| gnt_valid | output | 1 | grant issued |
| gnt_core | output | CW | core receiving the grant |
| gnt_state | output | 2 | state granted |
| snp_inv | output | NCORE | invalidate command per core |
| snp_down | output | NCORE | downgrade-to-shared command per core |
| snp_addr | output | ADDR_W | line address of the snoops |
| fwd_valid | output | 1 | a peer supplies the data |
| fwd_core | output | CW | supplying core |
| l2_valid | output | 1 | fetch from L2 |
| l2_addr | output | ADDR_W | L2 fetch address |

## Verification
The bench keeps its own model of every core's copy and chases a line through the full set of sharing patterns. These cover an E holder that must be downgraded, S holders that must be left alone, a Modified line passed from core to core, and an upgrade by an S holder. It also mixes two tags at one index, so a design that compared only indexes would snoop innocent cores. A design that answered a dirty hit from L2 would lose data, and the bench catches this as a wrong `l2_valid` or `fwd_core`. Evictions and silent upgrades reported mid-sequence expose a design whose copy stops following the cores, and simultaneous requests expose wrong arbitration order.

// File: rtl/sf_pkg.sv
package sf_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;
endpackage

// File: rtl/sf_arbiter.sv
module sf_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0]                   req,
    output logic [N-1:0]                   gnt,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx,
    output logic                           any
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = CW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sf_match.sv
module sf_match
    import sf_pkg::*;
#(
    parameter int N     = 4,
    parameter int TAG_W = 6
) (
    input  logic [N*TAG_W-1:0] tag_row,
    input  logic [N*2-1:0]     st_row,
    input  logic [TAG_W-1:0]   tag,
    output logic [N-1:0]       hit
);
    for (genvar c = 0; c < N; c++) begin : g_cmp
        assign hit[c] = (st_row[2*c +: 2] != ST_I) &&
                        (tag_row[c*TAG_W +: TAG_W] == tag);
    end
endmodule

// File: rtl/sf_resolve.sv
module sf_resolve
    import sf_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic [N-1:0]   hit,
    input  logic [N*2-1:0] st_row,
    input  logic [CW-1:0]  req_id,
    input  logic           write,
    output logic [N-1:0]   inv,
    output logic [N-1:0]   down,
    output logic           fwd_valid,
    output logic [CW-1:0]  fwd_id,
    output logic           need_l2,
    output logic [1:0]     gnt_st
);
    logic [N-1:0]  remote;
    logic [N-1:0]  m_mask;
    logic [N-1:0]  e_mask;
    logic          own;
    logic [1:0]    own_st;
    logic [CW-1:0] low_id;

    always_comb begin
        remote = '0;
        m_mask = '0;
        e_mask = '0;
        own    = 1'b0;
        own_st = ST_I;
        low_id = '0;
        for (int c = N - 1; c >= 0; c--) begin
            if (CW'(c) == req_id) begin
                own    = hit[c];
                own_st = st_row[2*c +: 2];
            end else if (hit[c]) begin
                remote[c] = 1'b1;
                low_id    = CW'(c);
                m_mask[c] = (st_row[2*c +: 2] == ST_M);
                e_mask[c] = (st_row[2*c +: 2] == ST_E);
            end
        end

        inv       = '0;
        down      = '0;
        fwd_valid = 1'b0;
        fwd_id    = '0;
        need_l2   = 1'b0;
        gnt_st    = ST_I;

        if (write) begin
            inv    = remote;
            gnt_st = ST_M;
            if (!own) begin
                if (|remote) begin
                    fwd_valid = 1'b1;
                    fwd_id    = low_id;
                end else begin
                    need_l2 = 1'b1;
                end
            end
        end else if (own) begin
            gnt_st = own_st;
        end else if (remote == '0) begin
            need_l2 = 1'b1;
            gnt_st  = ST_E;
        end else if (|m_mask) begin
            inv       = m_mask;
            fwd_valid = 1'b1;
            fwd_id    = low_id;
            gnt_st    = ST_M;
        end else begin
            down      = e_mask;
            fwd_valid = 1'b1;
            fwd_id    = low_id;
            gnt_st    = ST_S;
        end
    end
endmodule

// File: rtl/snoop_filter_dup.sv
module snoop_filter_dup
    import sf_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int NLINE  = 64,
    parameter int ADDR_W = 12
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [NCORE-1:0]                           req_valid,
    input  logic [NCORE-1:0]                           req_write,
    input  logic [NCORE*ADDR_W-1:0]                    req_addr,
    output logic [NCORE-1:0]                           req_ready,
    input  logic [NCORE-1:0]                           upd_valid,
    input  logic [NCORE*ADDR_W-1:0]                    upd_addr,
    input  logic [NCORE*2-1:0]                         upd_state,
    output logic                                       gnt_valid,
    output logic [((NCORE > 1) ? $clog2(NCORE) : 1)-1:0] gnt_core,
    output logic [1:0]                                 gnt_state,
    output logic [NCORE-1:0]                           snp_inv,
    output logic [NCORE-1:0]                           snp_down,
    output logic [ADDR_W-1:0]                          snp_addr,
    output logic                                       fwd_valid,
    output logic [((NCORE > 1) ? $clog2(NCORE) : 1)-1:0] fwd_core,
    output logic                                       l2_valid,
    output logic [ADDR_W-1:0]                          l2_addr
);
    localparam int CW    = (NCORE > 1) ? $clog2(NCORE) : 1;
    localparam int IDX_W = $clog2(NLINE);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              gv;
        logic [CW-1:0]     gc;
        logic [1:0]        gs;
        logic [NCORE-1:0]  inv;
        logic [NCORE-1:0]  dn;
        logic [ADDR_W-1:0] sa;
        logic              fv;
        logic [CW-1:0]     fc;
        logic              lv;
        logic [ADDR_W-1:0] la;
    } out_t;

    out_t o_d, o_q;

    logic [TAG_W-1:0] tag_d [NCORE][NLINE];
    logic [TAG_W-1:0] tag_q [NCORE][NLINE];
    logic [1:0]       st_d  [NCORE][NLINE];
    logic [1:0]       st_q  [NCORE][NLINE];

    // arbitration
    logic [CW-1:0] win;
    logic          any_req;

    sf_arbiter #(.N(NCORE)) u_arb (
        .req (req_valid),
        .gnt (req_ready),
        .idx (win),
        .any (any_req)
    );

    // selected request
    logic [ADDR_W-1:0]    sel_addr;
    logic                 sel_write;
    logic [IDX_W-1:0]     sel_idx;
    logic [TAG_W-1:0]     sel_tag;
    logic [NCORE*TAG_W-1:0] row_tag;
    logic [NCORE*2-1:0]   row_st;

    always_comb begin
        sel_addr  = req_addr[win*ADDR_W +: ADDR_W];
        sel_write = req_write[win];
        sel_idx   = sel_addr[IDX_W-1:0];
        sel_tag   = sel_addr[ADDR_W-1:IDX_W];
        for (int c = 0; c < NCORE; c++) begin
            row_tag[c*TAG_W +: TAG_W] = tag_q[c][sel_idx];
            row_st[2*c +: 2]          = st_q[c][sel_idx];
        end
    end

    logic [NCORE-1:0] hit;

    sf_match #(.N(NCORE), .TAG_W(TAG_W)) u_match (
        .tag_row (row_tag),
        .st_row  (row_st),
        .tag     (sel_tag),
        .hit     (hit)
    );

    logic [NCORE-1:0] r_inv, r_down;
    logic             r_fwd, r_l2;
    logic [CW-1:0]    r_fwd_id;
    logic [1:0]       r_gs;

    sf_resolve #(.N(NCORE), .CW(CW)) u_res (
        .hit       (hit),
        .st_row    (row_st),
        .req_id    (win),
        .write     (sel_write),
        .inv       (r_inv),
        .down      (r_down),
        .fwd_valid (r_fwd),
        .fwd_id    (r_fwd_id),
        .need_l2   (r_l2),
        .gnt_st    (r_gs)
    );

    // next-state: core reports first, then snoop effects, then the fill
    always_comb begin
        tag_d = tag_q;
        st_d  = st_q;
        for (int c = 0; c < NCORE; c++) begin
            if (upd_valid[c]) begin
                tag_d[c][upd_addr[c*ADDR_W +: IDX_W]] = upd_addr[c*ADDR_W + IDX_W +: TAG_W];
                st_d[c][upd_addr[c*ADDR_W +: IDX_W]]  = upd_state[2*c +: 2];
            end
        end
        o_d = '0;
        if (any_req) begin
            for (int c = 0; c < NCORE; c++) begin
                if (r_inv[c]) begin
                    st_d[c][sel_idx] = ST_I;
                end else if (r_down[c]) begin
                    st_d[c][sel_idx] = ST_S;
                end
            end
            tag_d[win][sel_idx] = sel_tag;
            st_d[win][sel_idx]  = r_gs;
            o_d.gv  = 1'b1;
            o_d.gc  = win;
            o_d.gs  = r_gs;
            o_d.inv = r_inv;
            o_d.dn  = r_down;
            o_d.sa  = (|(r_inv | r_down)) ? sel_addr : '0;
            o_d.fv  = r_fwd;
            o_d.fc  = r_fwd ? r_fwd_id : '0;
            o_d.lv  = r_l2;
            o_d.la  = r_l2 ? sel_addr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
            for (int c = 0; c < NCORE; c++) begin
                for (int l = 0; l < NLINE; l++) begin
                    tag_q[c][l] <= '0;
                    st_q[c][l]  <= ST_I;
                end
            end
        end else begin
            o_q   <= o_d;
            tag_q <= tag_d;
            st_q  <= st_d;
        end
    end

    assign gnt_valid = o_q.gv;
    assign gnt_core  = o_q.gc;
    assign gnt_state = o_q.gs;
    assign snp_inv   = o_q.inv;
    assign snp_down  = o_q.dn;
    assign snp_addr  = o_q.sa;
    assign fwd_valid = o_q.fv;
    assign fwd_core  = o_q.fc;
    assign l2_valid  = o_q.lv;
    assign l2_addr   = o_q.la;

    // checks
    assert_one_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
    assert_low_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> req_ready[0]);
    assert_grant_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $past(|req_ready));
    assert_one_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && l2_valid));
    assert_no_self_snoop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (!snp_inv[gnt_core] && !snp_down[gnt_core]));
    assert_inv_down_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_inv & snp_down) == '0);
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> (snp_inv == '0 && !fwd_valid && !l2_valid));
endmodule

// File: tb/snoop_filter_dup_tb.sv
module snoop_filter_dup_tb;
    localparam int NC = 4;
    localparam int NL = 64;
    localparam int AW = 12;
    localparam int IW = 6;
    localparam int TW = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n;
    logic [NC-1:0]  req_valid, req_write, req_ready;
    logic [NC*AW-1:0] req_addr;
    logic [NC-1:0]  upd_valid;
    logic [NC*AW-1:0] upd_addr;
    logic [NC*2-1:0] upd_state;
    logic           gnt_valid, fwd_valid, l2_valid;
    logic [1:0]     gnt_core, fwd_core, gnt_state;
    logic [NC-1:0]  snp_inv, snp_down;
    logic [AW-1:0]  snp_addr, l2_addr;

    snoop_filter_dup #(.NCORE(NC), .NLINE(NL), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_state(upd_state),
        .gnt_valid(gnt_valid), .gnt_core(gnt_core), .gnt_state(gnt_state),
        .snp_inv(snp_inv), .snp_down(snp_down), .snp_addr(snp_addr),
        .fwd_valid(fwd_valid), .fwd_core(fwd_core),
        .l2_valid(l2_valid), .l2_addr(l2_addr)
    );

    wire [40:0] obs = {gnt_valid, gnt_core, gnt_state, snp_inv, snp_down, snp_addr,
                       fwd_valid, fwd_core, l2_valid, l2_addr};

    int total = 0;
    int bad   = 0;

    logic [TW-1:0] mt [NC][NL];
    logic [1:0]    ms [NC][NL];

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // reference model of the requirements
    task automatic model_req(input int c, input logic [AW-1:0] a, input logic w,
                             output logic [40:0] e, output string lab,
                             output logic [NC-1:0] okm);
        int ix;
        int low;
        logic [TW-1:0] tg;
        logic [NC-1:0] rem, inv, dn;
        logic own, anym, fv, lv;
        logic [1:0] gs;
        ix = int'(a[IW-1:0]);
        tg = a[AW-1:IW];
        rem = '0; inv = '0; dn = '0; own = 1'b0; anym = 1'b0; low = -1;
        fv = 1'b0; lv = 1'b0; gs = 2'd0;
        for (int k = 0; k < NC; k++) begin
            if (ms[k][ix] != 2'd0 && mt[k][ix] == tg) begin
                if (k == c) own = 1'b1;
                else begin
                    rem[k] = 1'b1;
                    if (low < 0) low = k;
                    if (ms[k][ix] == 2'd3) anym = 1'b1;
                end
            end
        end
        if (w) begin
            inv = rem; gs = 2'd3;
            if (own) lab = "R7";
            else begin
                lab = "R6";
                if (rem != 0) fv = 1'b1; else lv = 1'b1;
            end
        end else if (own) begin
            gs = ms[c][ix]; lab = "R8";
        end else if (rem == 0) begin
            lv = 1'b1; gs = 2'd2; lab = "R2";
        end else if (anym) begin
            inv = rem; fv = 1'b1; gs = 2'd3; lab = "R5";
        end else begin
            for (int k = 0; k < NC; k++) dn[k] = rem[k] && (ms[k][ix] == 2'd2);
            fv = 1'b1; gs = 2'd1; lab = "R3";
        end
        for (int k = 0; k < NC; k++) begin
            if (inv[k]) ms[k][ix] = 2'd0;
            else if (dn[k]) ms[k][ix] = 2'd1;
        end
        mt[c][ix] = tg;
        ms[c][ix] = gs;
        e = {1'b1, 2'(c), gs, inv, dn, ((inv | dn) != 0) ? a : 12'h0,
             fv, fv ? 2'(low) : 2'd0, lv, lv ? a : 12'h0};
        okm = rem;
    endtask

    task automatic issue(input int c, input logic [AW-1:0] a, input logic w);
        logic [40:0] e;
        logic [NC-1:0] okm;
        string lab;
        @(negedge clk);
        #1 chk("R1 idle outputs", 64'(obs), 64'h0);
        req_valid[c] = 1'b1;
        req_write[c] = w;
        req_addr[c*AW +: AW] = a;
        #1 chk("R1 ready", 64'(req_ready), 64'(4'b1 << c));
        model_req(c, a, w, e, lab, okm);
        @(negedge clk);
        req_valid[c] = 1'b0;
        req_write[c] = 1'b0;
        #1 chk(lab, 64'(obs), 64'(e));
        chk("R4 snoop targets", 64'((snp_inv | snp_down) & ~okm), 64'h0);
    endtask

    task automatic upd(input int c, input logic [AW-1:0] a, input logic [1:0] st);
        @(negedge clk);
        upd_valid[c] = 1'b1;
        upd_addr[c*AW +: AW] = a;
        upd_state[2*c +: 2] = st;
        mt[c][int'(a[IW-1:0])] = a[AW-1:IW];
        ms[c][int'(a[IW-1:0])] = st;
        @(negedge clk);
        upd_valid[c] = 1'b0;
        #1 chk("R9 update quiet", 64'(obs), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [40:0] e1, e3;
        logic [NC-1:0] ok1, ok3;
        string l1, l3;
        rst_n = 1'b0;
        req_valid = '0; req_write = '0; req_addr = '0;
        upd_valid = '0; upd_addr = '0; upd_state = '0;
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < NL; l++) begin
                mt[c][l] = '0;
                ms[c][l] = 2'd0;
            end
        repeat (3) @(negedge clk);
        #1 chk("R10 in reset", 64'(obs), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R10 after reset", 64'(obs), 64'h0);

        // directed walk through the sharing patterns (index 5)
        issue(0, 12'h045, 1'b0);   // R2 fresh read -> E
        issue(1, 12'h045, 1'b0);   // R3 E holder downgraded
        issue(2, 12'h045, 1'b0);   // R3 S holders untouched
        issue(3, 12'h085, 1'b0);   // R4 other tag, same index
        issue(3, 12'h045, 1'b1);   // R6 write miss, invalidate all
        issue(0, 12'h045, 1'b0);   // R5 dirty migration
        issue(0, 12'h045, 1'b0);   // R8 own hit
        issue(1, 12'h045, 1'b0);   // R5
        issue(0, 12'h0C7, 1'b0);   // R2
        issue(1, 12'h0C7, 1'b0);   // R3
        issue(1, 12'h0C7, 1'b1);   // R7 upgrade
        upd(1, 12'h0C7, 2'd0);     // R9 eviction
        issue(0, 12'h0C7, 1'b0);   // R2 after eviction
        upd(0, 12'h0C7, 2'd3);     // R9 silent upgrade report
        issue(3, 12'h0C7, 1'b0);   // R5 from reported M
        issue(2, 12'h108, 1'b1);   // R6 write, no holder -> L2

        // R1 simultaneous requests
        @(negedge clk);
        req_valid[1] = 1'b1; req_addr[1*AW +: AW] = 12'h148;
        req_valid[3] = 1'b1; req_addr[3*AW +: AW] = 12'h108;
        #1 chk("R1 priority", 64'(req_ready), 64'h2);
        model_req(1, 12'h148, 1'b0, e1, l1, ok1);
        @(negedge clk);
        req_valid[1] = 1'b0;
        #1 chk("R1 second winner", 64'(req_ready), 64'h8);
        chk(l1, 64'(obs), 64'(e1));
        model_req(3, 12'h108, 1'b0, e3, l3, ok3);
        @(negedge clk);
        req_valid[3] = 1'b0;
        #1 chk(l3, 64'(obs), 64'(e3));
        chk("R4 snoop targets", 64'((snp_inv | snp_down) & ~ok3), 64'h0);

        // sweep: two indexes, three tags, all cores, reads, writes, reports
        seed = 32'h1234_5678;
        for (int k = 0; k < 600; k++) begin
            int c;
            int ix;
            logic [TW-1:0] tg;
            seed = seed * 32'd1103515245 + 32'd12345;
            c  = int'(seed[17:16]);
            ix = seed[18] ? 10 : 9;
            tg = TW'((seed[21:20] % 2'd3) + 2'd1);
            if (seed[26:24] == 3'd0) begin
                if (ms[c][ix] == 2'd2) upd(c, {mt[c][ix], 6'(ix)}, 2'd3);
                else if (ms[c][ix] != 2'd0) upd(c, {mt[c][ix], 6'(ix)}, 2'd0);
            end else begin
                issue(c, {tg, 6'(ix)}, seed[27]);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule